// File: doc/BRIEF.md
# Tagged Instruction Prefetch with Interrupt Injection

This block sits between instruction fetch and decode in a processor with 32-bit fixed-length instructions. It keeps two prefetched words, each carrying a 2-bit exception tag. On every execute step the decoder takes the oldest word and its tag, and the word fetched in the same step goes into the slot just vacated. A fetch that ends in a bus error is not dropped. It enters the buffer tagged as an abort and reaches the decoder in program order.

Pending fast and normal interrupt requests are not taken by redirecting the processor. When one is accepted, the block overwrites the next word to be handed out with a software-interrupt opcode and tags it with the interrupt kind. The execute stage inspects the tag when that instruction runs. A rewind flag tells it to lower the return address by one word for an injected slot, because that slot was never fetched. A redirect (a write to the PC or to the status) refills both slots from the new PC. The redirect is refused while an injected interrupt waits at the head, so that the interrupt is not lost.

Fetched words enter on a valid/ready stream (`in_*`) and decoded words leave on another (`out_*`). During normal execution the two streams move together. A word is offered to the decoder only while a fetched word is offered at the input. `in_ready` then follows `out_ready`, so a decoder stall also stalls fetch. While the buffer refills, `in_ready` is high and `out_valid` is low. The cycle in which a redirect or an injection is taken stalls both streams.

Top module: `tagged_prefetch`

## Requirements
- R1: Out of reset, `out_valid` is 0 and `in_ready` is 1. `fetch_addr` equals RESET_PC (default 0) for the first fill and RESET_PC+4 for the second.
- R2: Until two fill words have been accepted, `out_valid` stays 0. After that, `out_valid` is 1 exactly when `in_valid` is 1 and no redirect or injection is taken in that cycle.
- R3: Words reach `out_opcode` in the order they were accepted on the input, delayed by two exchanges. During normal execution `fetch_addr` = `cur_pc` + 8.
- R4: A word accepted with `in_err`=1 later appears with `out_tag`=1 (abort). Other fetched words appear with `out_tag`=0 (none).
- R5: When `fiq_req`=1 and `fiq_dis`=0 during normal execution, the next head becomes opcode 0xEF000000 with `out_tag`=3 (fast). A simultaneous normal request is not considered.
- R6: A normal interrupt is accepted only when `irq_req`=1, `irq_dis`=0 and no fast interrupt is accepted. The head then becomes 0xEF000000 with `out_tag`=2. A masked request leaves the head unchanged.
- R7: In the cycle an interrupt is injected, `in_ready` and `out_valid` are 0, so the injection wins over an exchange. While the head carries tag 2 or 3, no further injection takes place.
- R8: A taken redirect stalls both streams in its cycle and then refills the buffer from `cur_pc` and `cur_pc`+4, with `out_valid` at 0 during both fills.
- R9: A redirect is ignored while the head carries tag 2 or 3. The head and `out_valid` are unchanged.
- R10: `out_rewind` is 1 exactly when `out_tag` is 2 or 3.
- R11: With `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the head opcode and tag hold.
- R12: If a redirect and an interrupt request arrive together, the redirect is taken first. The interrupt is injected in the first cycle of normal execution after the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Current program counter of the execute stage |
| redirect | input | 1 | PC or status written; request a refill |
| fiq_req | input | 1 | Fast interrupt pending |
| fiq_dis | input | 1 | Fast interrupt disable flag |
| irq_req | input | 1 | Normal interrupt pending |
| irq_dis | input | 1 | Normal interrupt disable flag |
| fetch_addr | output | 32 | Address of the word to be supplied on `in_word` |
| in_valid | input | 1 | Fetched word present |
| in_ready | output | 1 | Buffer accepts the fetched word |
| in_word | input | 32 | Fetched instruction word |
| in_err | input | 1 | Bus error on this fetch |
| out_valid | output | 1 | Head word offered to the decoder |
| out_ready | input | 1 | Decoder takes the head word |
| out_opcode | output | 32 | Head opcode |
| out_tag | output | 2 | Head tag: 0 none, 1 abort, 2 normal interrupt, 3 fast interrupt |
| out_rewind | output | 1 | Return address must be lowered by 4 |

## Verification
Two functions can fall in the same cycle: an interrupt injection and a fetch exchange, and also a redirect and a pending interrupt request. The bench raises both interrupt requests while a fetched word and a ready decoder are present. It expects both streams to stall in that cycle and the fast-interrupt opcode at the head afterwards. It also asserts a redirect together with a normal interrupt request. It then expects the full refill first and the injection only in the first normal cycle after it.

// File: rtl/tpf_pkg.sv
`timescale 1ns/1ps
package tpf_pkg;
  typedef enum logic [1:0] {
    TAG_NONE  = 2'd0,
    TAG_ABORT = 2'd1,
    TAG_IRQ   = 2'd2,
    TAG_FIQ   = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    SQ_FILL0 = 2'd0,
    SQ_FILL1 = 2'd1,
    SQ_RUN   = 2'd2
  } seq_e;
endpackage

// File: rtl/tpf_prio.sv
`timescale 1ns/1ps
// Fast request outranks normal; each gated by its disable flag.
module tpf_prio
  import tpf_pkg::*;
(
  input  logic fiq_req,
  input  logic fiq_dis,
  input  logic irq_req,
  input  logic irq_dis,
  output logic take,
  output tag_e take_tag
);
  logic fiq_ok, irq_ok;
  always_comb begin
    fiq_ok   = fiq_req && !fiq_dis;
    irq_ok   = irq_req && !irq_dis;
    take     = fiq_ok || irq_ok;
    take_tag = fiq_ok ? TAG_FIQ : TAG_IRQ;
  end
endmodule

// File: rtl/tpf_slots.sv
`timescale 1ns/1ps
// Two tagged slots with a toggling head index.
module tpf_slots
  import tpf_pkg::*;
#(
  parameter int          W      = 32,
  parameter logic [31:0] SWI_OP = 32'hEF00_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xchg_en,
  input  logic [W-1:0] xchg_word,
  input  tag_e         xchg_tag,
  input  logic         inj_en,
  input  tag_e         inj_tag,
  output logic [W-1:0] head_op,
  output tag_e         head_tag
);
  localparam int NSLOT = 2;

  logic [W-1:0] op_q  [NSLOT];
  tag_e         tag_q [NSLOT];
  logic         head_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        op_q[g]  <= '0;
        tag_q[g] <= TAG_NONE;
      end else if (inj_en && (head_q == 1'(g))) begin
        op_q[g]  <= SWI_OP[W-1:0];
        tag_q[g] <= inj_tag;
      end else if (xchg_en && (head_q == 1'(g))) begin
        op_q[g]  <= xchg_word;
        tag_q[g] <= xchg_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 head_q <= 1'b0;
    else if (xchg_en && !inj_en) head_q <= ~head_q;
  end

  assign head_op  = op_q[head_q];
  assign head_tag = tag_q[head_q];
endmodule

// File: rtl/tpf_seq.sv
`timescale 1ns/1ps
// Refill sequencer and fetch address generation.
module tpf_seq
  import tpf_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refill,
  input  logic          xchg,
  input  logic [AW-1:0] cur_pc,
  output logic          running,
  output logic [AW-1:0] fetch_addr
);
  localparam logic [AW-1:0] STEP = AW'(4);

  seq_e          st_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_FILL0;
      base_q <= RESET_PC[AW-1:0];
    end else if (refill) begin
      st_q   <= SQ_FILL0;
      base_q <= cur_pc;
    end else if (xchg) begin
      case (st_q)
        SQ_FILL0: st_q <= SQ_FILL1;
        SQ_FILL1: st_q <= SQ_RUN;
        default:  st_q <= SQ_RUN;
      endcase
    end
  end

  always_comb begin
    running = (st_q == SQ_RUN);
    case (st_q)
      SQ_FILL0: fetch_addr = base_q;
      SQ_FILL1: fetch_addr = base_q + STEP;
      default:  fetch_addr = cur_pc + (STEP << 1);
    endcase
  end
endmodule

// File: rtl/tagged_prefetch.sv
`timescale 1ns/1ps
module tagged_prefetch
  import tpf_pkg::*;
#(
  parameter int          W        = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [31:0] SWI_OP   = 32'hEF00_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_pc,
  input  logic         redirect,
  input  logic         fiq_req,
  input  logic         fiq_dis,
  input  logic         irq_req,
  input  logic         irq_dis,
  output logic [W-1:0] fetch_addr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  input  logic         in_err,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_opcode,
  output logic [1:0]   out_tag,
  output logic         out_rewind
);
  logic running, acc, head_int, redir_take, inject, xchg;
  tag_e acc_tag, head_tag, wr_tag;

  tpf_prio u_prio (
    .fiq_req (fiq_req), .fiq_dis (fiq_dis),
    .irq_req (irq_req), .irq_dis (irq_dis),
    .take    (acc),     .take_tag(acc_tag)
  );

  always_comb begin
    head_int   = (head_tag == TAG_IRQ) || (head_tag == TAG_FIQ);
    redir_take = redirect && !head_int;
    inject     = running && acc && !head_int && !redir_take;
    in_ready   = !redir_take && !inject && (!running || out_ready);
    out_valid  = running && in_valid && !redir_take && !inject;
    xchg       = in_valid && in_ready;
    wr_tag     = in_err ? TAG_ABORT : TAG_NONE;
  end

  tpf_slots #(.W(W), .SWI_OP(SWI_OP)) u_slots (
    .clk      (clk),      .rst_n    (rst_n),
    .xchg_en  (xchg),     .xchg_word(in_word), .xchg_tag(wr_tag),
    .inj_en   (inject),   .inj_tag  (acc_tag),
    .head_op  (out_opcode), .head_tag(head_tag)
  );

  tpf_seq #(.AW(W), .RESET_PC(RESET_PC)) u_seq (
    .clk    (clk),     .rst_n     (rst_n),
    .refill (redir_take), .xchg   (xchg),
    .cur_pc (cur_pc),  .running   (running),
    .fetch_addr(fetch_addr)
  );

  assign out_tag    = head_tag;
  assign out_rewind = head_int;
endmodule

// File: rtl/tagged_prefetch_chk.sv
`timescale 1ns/1ps
module tagged_prefetch_chk #(
  parameter int          W      = 32,
  parameter logic [31:0] SWI_OP = 32'hEF00_0000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fiq_req,
  input logic         fiq_dis,
  input logic         irq_req,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_opcode,
  input logic [1:0]   out_tag,
  input logic         out_rewind,
  input logic         inject
);
  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && (in_ready == out_ready)));

  assert_fiq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && fiq_req && !fiq_dis) |=> (out_tag == 2'd3 && out_opcode == SWI_OP[W-1:0]));

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inject && !(fiq_req && !fiq_dis)) |=> (out_tag == 2'd2));

  assert_inj_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inject |-> (!in_ready && !out_valid));

  assert_rewind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_rewind |-> (out_opcode == SWI_OP[W-1:0]));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fiq_req && !irq_req) |=>
      ($stable(out_opcode) && $stable(out_tag)));

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rewind && !out_ready) |=> out_rewind);
endmodule

bind tagged_prefetch tagged_prefetch_chk #(.W(W), .SWI_OP(SWI_OP)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .fiq_dis(fiq_dis),
  .irq_req(irq_req), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
  .out_tag(out_tag), .out_rewind(out_rewind), .inject(inject)
);

// File: tb/tagged_prefetch_bench.sv
`timescale 1ns/1ps
module tagged_prefetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = 32'h1000;
  logic        redirect = 0, fiq_req = 0, fiq_dis = 0, irq_req = 0, irq_dis = 0;
  logic [31:0] fetch_addr;
  logic        in_valid = 0, in_ready, in_err = 0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_ready = 0, out_rewind;
  logic [31:0] out_opcode;
  logic [1:0]  out_tag;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tagged_prefetch u_tagged_prefetch (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .redirect(redirect),
    .fiq_req(fiq_req), .fiq_dis(fiq_dis), .irq_req(irq_req), .irq_dis(irq_dis),
    .fetch_addr(fetch_addr), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_err(in_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_opcode(out_opcode), .out_tag(out_tag),
    .out_rewind(out_rewind)
  );

  localparam logic [31:0] SWI = 32'hEF00_0000;
  localparam logic [31:0] F0 = 32'h1111_0000, F1 = 32'h2222_0001;

  typedef struct packed {
    logic [31:0] word;
    logic        err;
    logic [31:0] exp_op;
    logic [1:0]  exp_tag;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'hA000_0000, 1'b0, F0,           2'd0},
    '{32'hA000_0001, 1'b1, F1,           2'd1},
    '{32'hA000_0002, 1'b0, 32'hA000_0000, 2'd0},
    '{32'hA000_0003, 1'b0, 32'hA000_0001, 2'd1},
    '{32'hA000_0004, 1'b0, 32'hA000_0002, 2'd0},
    '{32'hA000_0005, 1'b0, 32'hA000_0003, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'b0, in_ready}, 32'd1);
    chk("R1 addr0", fetch_addr, 32'h0);
    // R2 fills
    in_valid = 1; in_word = F0; in_err = 0; out_ready = 1;
    #0.5;
    chk("R2 fill0 no out", {31'b0, out_valid}, 32'd0);
    tick;
    chk("R1 addr1", fetch_addr, 32'h4);
    in_word = F1; in_err = 1;
    #0.5;
    chk("R2 fill1 no out", {31'b0, out_valid}, 32'd0);
    tick;
    // R3/R4 table walk
    for (int i = 0; i < 6; i++) begin
      in_word = VEC[i].word; in_err = VEC[i].err;
      #0.5;
      chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
      chk("R3 opcode", out_opcode, VEC[i].exp_op);
      chk("R4 tag", {30'b0, out_tag}, {30'b0, VEC[i].exp_tag});
      chk("R10 no rewind", {31'b0, out_rewind}, 32'd0);
      chk("R3 run addr", fetch_addr, cur_pc + 32'd8);
      tick;
    end
    // R11 back-pressure, head = A4
    out_ready = 0; in_word = 32'hB000_0000; in_err = 0;
    #0.5;
    chk("R11 in_ready", {31'b0, in_ready}, 32'd0);
    chk("R11 out_valid", {31'b0, out_valid}, 32'd1);
    tick;
    chk("R11 head held", out_opcode, 32'hA000_0004);
    // R5/R7 both requests with a ready exchange pending
    out_ready = 1; fiq_req = 1; irq_req = 1;
    #0.5;
    chk("R7 in_ready", {31'b0, in_ready}, 32'd0);
    chk("R7 out_valid", {31'b0, out_valid}, 32'd0);
    tick;
    fiq_req = 0; out_ready = 0;
    #0.5;
    chk("R5 opcode", out_opcode, SWI);
    chk("R5 tag fast", {30'b0, out_tag}, 32'd3);
    chk("R10 rewind", {31'b0, out_rewind}, 32'd1);
    // R7 no re-injection while head tagged; irq still pending
    tick;
    chk("R7 head kept", {30'b0, out_tag}, 32'd3);
    irq_req = 0;
    // R9 redirect ignored
    redirect = 1; cur_pc = 32'h2000;
    #0.5;
    chk("R9 out_valid", {31'b0, out_valid}, 32'd1);
    tick;
    redirect = 0; cur_pc = 32'h1000;
    #0.5;
    chk("R9 head kept", {30'b0, out_tag}, 32'd3);
    chk("R9 still valid", {31'b0, out_valid}, 32'd1);
    // hand the injected word out
    out_ready = 1; in_word = 32'hB000_0000;
    #0.5;
    chk("R5 handed out", out_opcode, SWI);
    tick;
    chk("R3 next head", out_opcode, 32'hA000_0005);
    // R6 masked normal request
    out_ready = 0; irq_req = 1; irq_dis = 1;
    tick;
    chk("R6 masked", {30'b0, out_tag}, 32'd0);
    chk("R6 masked op", out_opcode, 32'hA000_0005);
    // R6 fast masked, normal open
    fiq_req = 1; fiq_dis = 1; irq_dis = 0;
    tick;
    fiq_req = 0; irq_req = 0;
    #0.5;
    chk("R6 tag normal", {30'b0, out_tag}, 32'd2);
    chk("R6 opcode", out_opcode, SWI);
    out_ready = 1; in_word = 32'hB000_0001;
    tick;
    chk("R3 after irq", out_opcode, 32'hB000_0000);
    // R8/R12 redirect with normal request together
    redirect = 1; cur_pc = 32'h3000; irq_req = 1;
    #0.5;
    chk("R8 stall in", {31'b0, in_ready}, 32'd0);
    chk("R8 stall out", {31'b0, out_valid}, 32'd0);
    tick;
    redirect = 0;
    in_word = 32'hC000_0000;
    #0.5;
    chk("R8 addr base", fetch_addr, 32'h3000);
    chk("R12 no inject in fill", {31'b0, in_ready}, 32'd1);
    chk("R8 fill no out", {31'b0, out_valid}, 32'd0);
    tick;
    in_word = 32'hC000_0001;
    #0.5;
    chk("R8 addr +4", fetch_addr, 32'h3004);
    chk("R8 fill1 no out", {31'b0, out_valid}, 32'd0);
    tick;
    chk("R3 run addr after refill", fetch_addr, 32'h3008);
    chk("R12 inject stall", {31'b0, in_ready}, 32'd0);
    chk("R12 inject no out", {31'b0, out_valid}, 32'd0);
    tick;
    irq_req = 0;
    #0.5;
    chk("R12 injected tag", {30'b0, out_tag}, 32'd2);
    chk("R12 injected op", out_opcode, SWI);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule